// File: doc/BRIEF.md
# Serial GNSS I/Q Sample Deserializer

This block takes the one-bit serial baseband stream of a GNSS RF front-end and turns it into packed words that a host can read. The front-end supplies a data line and an active-high sync strobe. Both are qualified by a sample-clock enable, which stands in for the rising edge of the front-end's 8.192 MHz sample clock. Every four qualified bits form one complex sample of 2 bits per channel, so the sample rate is 2.048 MS/s. The bits arrive in the order in-phase sign, in-phase magnitude, quadrature sign, quadrature magnitude. The sync pulse sits on the in-phase sign bit.

A deframer locks onto the sync pulse and flags any sync that is missing or out of place. It reorders each frame into a nibble with the quadrature pair in the upper half and the in-phase pair in the lower half. A packer gathers eight nibbles into a 32-bit word, and each full word goes into a 256-entry capture FIFO. A small register bus with three addresses gives the host control, status with sticky error flags, and a data port that pops one word per read.

The bus and the sample enable share one clock. The serial inputs pass through one register stage before the deframer sees them.

Top module: `gnss_iq_capture`

## Requirements
- R1: `serData` and `serSync` are captured into one register stage only in cycles where `sampleEn` is high. Their values while `sampleEn` is low have no effect.
- R2: While the block is not locked, bits without sync are discarded. A bit that carries sync sets the lock and is taken as the in-phase sign bit of a new frame.
- R3: The serial frame order is I sign, I magnitude, Q sign, Q magnitude. The stored nibble is bit3 = Q sign, bit2 = Q magnitude, bit1 = I sign, bit0 = I magnitude.
- R4: Eight consecutive nibbles form one 32-bit word. The earliest nibble is in bits [3:0] and the latest is in bits [31:28].
- R5: If a locked frame start arrives without sync, the sticky sync-error flag (status bit 19) is set and the lock is dropped. Bits are then discarded until the next sync. If sync arrives at any other frame position, the flag is set, the partial frame is discarded and a new frame starts on that bit. Packer contents are kept in both cases.
- R6: The FIFO holds up to 256 words. Status bits [15:0] report the fill level and status bit 16 reports the lock.
- R7: A word that completes while the FIFO holds 256 words is dropped, and the sticky overflow flag (status bit 17) is set. Writing 1 to that bit of the status register (address 1) clears it.
- R8: A read of the data register (address 2) returns the oldest word and removes it. A read from an empty FIFO returns zero and sets the sticky underflow flag (status bit 18). That flag is cleared by writing 1 to it.
- R9: Writing the control register (address 0) with bit 1 set flushes the FIFO, empties the packer and drops the lock.
- R10: Bit 0 of the control register enables capture, and it reads back at address 0. While it is 0, qualified bits are ignored. It is 0 after reset.
- R11: Read data appears on `busRdata` one clock after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common clock for the bus and the sampling |
| rstN | input | 1 | Active-low synchronous reset |
| sampleEn | input | 1 | Qualifies one serial bit (sample-clock rising edge) |
| serData | input | 1 | Serial sign/magnitude data from the front-end |
| serSync | input | 1 | Active-high frame sync, coincides with the I sign bit |
| busAddr | input | 2 | Register address: 0 control, 1 status, 2 data |
| busWr | input | 1 | Write strobe |
| busRd | input | 1 | Read strobe |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Registered read data |

## Verification
The assertions take for granted that the read and write strobes are single-cycle pulses with a stable address. They also assume that `sampleEn` is a single-cycle strobe, so each serial bit is seen exactly once. The stimulus raises `sampleEn` for one cycle per bit and leaves an idle cycle between bits. During that idle cycle it drives inverted data and a raised sync, and all of this must be ignored. Bus accesses are one-cycle pulses issued on the falling edge. The bench lets the three-cycle path from the input register to the FIFO settle before any status or data read that depends on it.

// File: rtl/gnss_cap_pkg.sv
package gnss_cap_pkg;
  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  localparam int CTRL_EN  = 0;
  localparam int CTRL_CLR = 1;

  localparam int ST_LOCK = 16;
  localparam int ST_OVF  = 17;
  localparam int ST_UDF  = 18;
  localparam int ST_SERR = 19;

  // strobes from the control side to the datapath
  typedef struct packed {
    logic enable;
    logic clear;
    logic pop;
  } capStrobe_t;
endpackage

// File: rtl/gnss_cap_datapath.sv
module gnss_cap_datapath
  import gnss_cap_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              serData,
  input  logic              serSync,
  input  capStrobe_t        strb,
  output logic [LVL_W-1:0]  level,
  output logic              locked,
  output logic [WORD_W-1:0] headWord,
  output logic              syncErrPulse,
  output logic              overflowPulse
);
  localparam int NIBS  = WORD_W / 4;
  localparam int CNT_W = $clog2(NIBS);
  localparam int PTR_W = $clog2(DEPTH);
  localparam logic [LVL_W-1:0] FULL_LVL  = LVL_W'(DEPTH);
  localparam logic [CNT_W-1:0] LAST_SLOT = CNT_W'(NIBS - 1);
  localparam logic [PTR_W-1:0] LAST_PTR  = PTR_W'(DEPTH - 1);

  // input register stage
  logic dReg, sReg, bitStb;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dReg   <= 1'b0;
      sReg   <= 1'b0;
      bitStb <= 1'b0;
    end else begin
      bitStb <= sampleEn & strb.enable;
      if (sampleEn) begin
        dReg <= serData;
        sReg <= serSync;
      end
    end
  end

  // deframer
  logic [1:0] pos;
  logic [2:0] part;   // [2] I sign, [1] I mag, [0] Q sign
  logic       nibValid;
  logic [3:0] nib;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pos <= '0; part <= '0; locked <= 1'b0;
      nibValid <= 1'b0; nib <= '0; syncErrPulse <= 1'b0;
    end else begin
      nibValid     <= 1'b0;
      syncErrPulse <= 1'b0;
      if (strb.clear) begin
        locked <= 1'b0;
        pos    <= '0;
      end else if (bitStb) begin
        if (sReg) begin
          if (locked && pos != 2'd0) syncErrPulse <= 1'b1;
          locked  <= 1'b1;
          part[2] <= dReg;
          pos     <= 2'd1;
        end else if (locked) begin
          if (pos == 2'd0) begin
            syncErrPulse <= 1'b1;
            locked       <= 1'b0;
          end else begin
            pos <= pos + 2'd1;
            if (pos == 2'd1) part[1] <= dReg;
            else if (pos == 2'd2) part[0] <= dReg;
            else begin
              nibValid <= 1'b1;
              nib      <= {part[0], dReg, part[2], part[1]};
            end
          end
        end
      end
    end
  end

  // packer and capture FIFO
  logic [CNT_W-1:0]  slot;
  logic [WORD_W-1:0] acc;
  logic [WORD_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wrPtr, rdPtr;
  logic wordDone, doPush, doPop;
  logic [WORD_W-1:0] fullWord;

  always_comb begin
    wordDone = nibValid && (slot == LAST_SLOT) && !strb.clear;
    doPush   = wordDone && (level != FULL_LVL);
    doPop    = strb.pop && (level != '0) && !strb.clear;
    fullWord = {nib, acc[WORD_W-5:0]};
  end

  always_ff @(posedge clk) begin
    if (doPush) mem[wrPtr] <= fullWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN || strb.clear) begin
      slot <= '0; acc <= '0; wrPtr <= '0; rdPtr <= '0; level <= '0;
      overflowPulse <= 1'b0;
    end else begin
      overflowPulse <= wordDone && !doPush;
      if (nibValid) begin
        if (slot == LAST_SLOT) begin
          slot <= '0;
          acc  <= '0;
        end else begin
          slot <= slot + 1'b1;
          acc[{slot, 2'b00} +: 4] <= nib;
        end
      end
      if (doPush) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (doPop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
      case ({doPush, doPop})
        2'b10:   level <= level + 1'b1;
        2'b01:   level <= level - 1'b1;
        default: level <= level;
      endcase
    end
  end

  assign headWord = mem[rdPtr];

  p_level_max_r6: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);
  p_clear_unlocks_r9: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (!locked && level == '0));
  p_no_lock_without_sync_r2: assert property (@(posedge clk) disable iff (!rstN)
    (!locked && bitStb && !sReg && !strb.clear) |=> !locked);
  p_nibble_needs_lock_r5: assert property (@(posedge clk) disable iff (!rstN)
    nibValid |-> $past(locked));
  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wordDone && level == FULL_LVL && !strb.pop) |=> (level == FULL_LVL && overflowPulse));
endmodule

// File: rtl/gnss_cap_ctrl.sv
module gnss_cap_ctrl
  import gnss_cap_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LVL_W  = 9
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata,
  input  logic [LVL_W-1:0]  level,
  input  logic              locked,
  input  logic [WORD_W-1:0] headWord,
  input  logic              syncErrPulse,
  input  logic              overflowPulse,
  output capStrobe_t        strb
);
  logic enReg, ovfFlag, udfFlag, serrFlag;
  logic wrCtrl, wrStat, rdData, emptyRead;
  logic [WORD_W-1:0] statusWord;

  always_comb begin
    wrCtrl    = busWr && busAddr == ADDR_CTRL;
    wrStat    = busWr && busAddr == ADDR_STAT;
    rdData    = busRd && busAddr == ADDR_DATA;
    emptyRead = rdData && level == '0;
    strb.enable = enReg;
    strb.clear  = wrCtrl && busWdata[CTRL_CLR];
    strb.pop    = rdData && level != '0;
    statusWord = '0;
    statusWord[LVL_W-1:0] = level;
    statusWord[ST_LOCK]   = locked;
    statusWord[ST_OVF]    = ovfFlag;
    statusWord[ST_UDF]    = udfFlag;
    statusWord[ST_SERR]   = serrFlag;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      enReg <= 1'b0; ovfFlag <= 1'b0; udfFlag <= 1'b0; serrFlag <= 1'b0;
      busRdata <= '0;
    end else begin
      if (wrCtrl) enReg <= busWdata[CTRL_EN];
      if (overflowPulse) ovfFlag <= 1'b1;
      else if (wrStat && busWdata[ST_OVF]) ovfFlag <= 1'b0;
      if (emptyRead) udfFlag <= 1'b1;
      else if (wrStat && busWdata[ST_UDF]) udfFlag <= 1'b0;
      if (syncErrPulse) serrFlag <= 1'b1;
      else if (wrStat && busWdata[ST_SERR]) serrFlag <= 1'b0;
      if (busRd) begin
        case (busAddr)
          ADDR_CTRL: busRdata <= WORD_W'(enReg);
          ADDR_STAT: busRdata <= statusWord;
          ADDR_DATA: busRdata <= (level != '0) ? headWord : '0;
          default:   busRdata <= '0;
        endcase
      end
    end
  end

  p_ovf_sticky_r7: assert property (@(posedge clk) disable iff (!rstN)
    (ovfFlag && !(wrStat && busWdata[ST_OVF])) |=> ovfFlag);
  p_empty_read_zero_r8: assert property (@(posedge clk) disable iff (!rstN)
    emptyRead |=> (busRdata == '0 && udfFlag));
  p_rdata_hold_r11: assert property (@(posedge clk) disable iff (!rstN)
    !busRd |=> $stable(busRdata));
endmodule

// File: rtl/gnss_iq_capture.sv
module gnss_iq_capture
  import gnss_cap_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sampleEn,
  input  logic              serData,
  input  logic              serSync,
  input  logic [1:0]        busAddr,
  input  logic              busWr,
  input  logic              busRd,
  input  logic [WORD_W-1:0] busWdata,
  output logic [WORD_W-1:0] busRdata
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  capStrobe_t        strb;
  logic [LVL_W-1:0]  level;
  logic              locked, syncErrPulse, overflowPulse;
  logic [WORD_W-1:0] headWord;

  gnss_cap_datapath #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_dp (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .serData(serData),
    .serSync(serSync), .strb(strb), .level(level), .locked(locked),
    .headWord(headWord), .syncErrPulse(syncErrPulse),
    .overflowPulse(overflowPulse));

  gnss_cap_ctrl #(.WORD_W(WORD_W), .LVL_W(LVL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .level(level), .locked(locked),
    .headWord(headWord), .syncErrPulse(syncErrPulse),
    .overflowPulse(overflowPulse), .strb(strb));
endmodule

// File: tb/sim_gnss_iq_capture.sv
module sim_gnss_iq_capture;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sampleEn = 1'b0, serData = 1'b0, serSync = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  int checks = 0, failures = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gnss_iq_capture u0 (.clk(clk), .rstN(rstN), .sampleEn(sampleEn),
    .serData(serData), .serSync(serSync), .busAddr(busAddr), .busWr(busWr),
    .busRd(busRd), .busWdata(busWdata), .busRdata(busRdata));

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [3:0] nibOf(input int n);
    return 4'((n * 5 + 3) & 15);
  endfunction

  function automatic logic [31:0] wordOf(input int seed);
    logic [31:0] w;
    for (int k = 0; k < 8; k++) w[k*4 +: 4] = nibOf(seed + k);
    return w;
  endfunction

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic sendBit(input logic d, input logic s);
    @(negedge clk);
    serData = d; serSync = s; sampleEn = 1'b1;
    @(negedge clk);
    sampleEn = 1'b0; serData = ~d; serSync = 1'b1; // must be ignored (R1)
  endtask

  task automatic sendFrame(input logic [3:0] nb);
    sendBit(nb[1], 1'b1);
    sendBit(nb[0], 1'b0);
    sendBit(nb[3], 1'b0);
    sendBit(nb[2], 1'b0);
  endtask

  task automatic sendFrames(input int count, input int seed);
    for (int k = 0; k < count; k++) sendFrame(nibOf(seed + k));
    idle(4);
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    busAddr = a; busRd = 1'b1;
    @(negedge clk);
    busRd = 1'b0;
    d = busRdata;
  endtask

  task automatic testReset();
    logic [31:0] v;
    check(busRdata == 0, "R11 rdata after reset", busRdata, 0);
    busRead(0, v); check(v == 0, "R10 enable off after reset", v, 0);
    busRead(1, v); check(v == 0, "R6 status after reset", v, 0);
  endtask

  task automatic testDisabled();
    logic [31:0] v;
    sendFrames(8, 0);
    busRead(1, v); check(v == 0, "R10 disabled capture ignored", v, 0);
  endtask

  task automatic testBasic();
    logic [31:0] v;
    busWrite(0, 32'h1);
    busRead(0, v); check(v == 1, "R10 enable readback", v, 1);
    sendBit(1, 0); sendBit(0, 0); sendBit(1, 0);
    idle(3);
    busRead(1, v); check(v == 0, "R2 unsynced bits discarded", v, 0);
    sendFrames(8, 0);
    busRead(1, v); check(v == 32'h0001_0001, "R6 level and lock", v, 32'h0001_0001);
    busRead(2, v); check(v == wordOf(0), "R3 R4 packed word", v, wordOf(0));
    busRead(1, v); check(v[15:0] == 0, "R8 read pops", v, 0);
  endtask

  task automatic testOrder();
    logic [31:0] v;
    sendFrames(16, 8);
    busRead(1, v); check(v[15:0] == 2, "R6 level two", v, 2);
    busRead(2, v); check(v == wordOf(8), "R8 oldest first", v, wordOf(8));
    busRead(2, v); check(v == wordOf(16), "R8 second word", v, wordOf(16));
    sendFrame(4'b1000); sendFrame(4'b0100); sendFrame(4'b0010);
    sendFrame(4'b0001); sendFrame(4'b1111); sendFrame(4'b0000);
    sendFrame(4'b1010); sendFrame(4'b0101); idle(4);
    busRead(2, v); check(v == 32'h5A0F_1248, "R3 single-bit positions", v, 32'h5A0F_1248);
  endtask

  task automatic testUnderflow();
    logic [31:0] v;
    busRead(2, v); check(v == 0, "R8 empty read zero", v, 0);
    busRead(1, v); check(v[18] == 1, "R8 underflow flag set", v, 32'h4_0000);
    busWrite(1, 32'h4_0000);
    busRead(1, v); check(v[18] == 0, "R8 underflow cleared", v, 0);
  endtask

  task automatic testMissingSync();
    logic [31:0] v;
    busWrite(0, 32'h3);
    sendFrames(3, 30);
    sendBit(1, 0); sendBit(0, 0); sendBit(1, 0); sendBit(1, 0);
    idle(3);
    busRead(1, v); check(v[19:16] == 4'b1000, "R5 missing sync error unlock", v, 32'h8_0000);
    sendFrames(5, 33);
    busRead(2, v); check(v == wordOf(30), "R5 packer kept over missing sync", v, wordOf(30));
    busWrite(1, 32'h8_0000);
    busRead(1, v); check(v[19] == 0, "R5 sync error cleared", v, 0);
  endtask

  task automatic testMidSync();
    logic [31:0] v;
    busWrite(0, 32'h3);
    sendBit(1, 1); sendBit(0, 0);
    sendFrames(8, 50);
    busRead(1, v); check(v[19:16] == 4'b1001 && v[15:0] == 1, "R5 mid-frame sync", v, 32'h9_0001);
    busRead(2, v); check(v == wordOf(50), "R5 partial frame discarded", v, wordOf(50));
    busWrite(1, 32'h8_0000);
  endtask

  task automatic testClear();
    logic [31:0] v;
    sendFrames(19, 60);
    busRead(1, v); check(v[15:0] == 2, "R9 setup level", v, 2);
    busWrite(0, 32'h3);
    busRead(1, v); check(v == 0, "R9 clear flushes and unlocks", v, 0);
    sendFrames(8, 40);
    busRead(2, v); check(v == wordOf(40), "R9 packer reset", v, wordOf(40));
  endtask

  task automatic testOverflow();
    logic [31:0] v;
    busWrite(0, 32'h3);
    sendFrames(8 * 257, 100);
    busRead(1, v); check(v[17] == 1 && v[15:0] == 256, "R7 full and overflow", v, 32'h2_0100);
    busRead(2, v); check(v == wordOf(100), "R6 first word kept", v, wordOf(100));
    for (int w = 1; w < 256; w++) busRead(2, v);
    check(v == wordOf(100 + 8 * 255), "R6 word 256 kept", v, wordOf(100 + 8 * 255));
    busRead(2, v); check(v == 0, "R7 extra word dropped", v, 0);
    busWrite(1, 32'h6_0000);
    busRead(1, v); check(v[18:17] == 0, "R7 overflow cleared", v, 0);
  endtask

  initial begin
    idle(3);
    rstN = 1'b1;
    idle(2);
    testReset();
    testDisabled();
    testBasic();
    testOrder();
    testUnderflow();
    testMissingSync();
    testMidSync();
    testClear();
    testOverflow();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule